// File: doc/BRIEF.md
# Pipelined Worst-Case Cycle Estimator

This block computes a worst-case cycle count for a straight-line run of instructions on a simple two-stage machine. The machine has a fetch unit that fills a small opcode queue while an execute unit works through instructions. Each accepted input describes one instruction: its opcode length in bytes, the data bytes it reads, the data bytes it writes, and its minimum execute cycles. A constant parameter gives the number of cycles per memory access, and another gives the queue depth.

Between instructions the block keeps two pieces of state. The first is the number of opcode bytes already queued for the next instruction. The second is a residue: the cycles already spent on a fetch that has not yet completed. From these it decides how much of each instruction's fetch time is hidden behind the previous execution, how much is charged in full, and how much is charged as a leftover part of one access. It also keeps a plain total in which fetch and execute never overlap, so the two figures can be compared.

A flag sent with the first descriptor of a block clears the carried state and restarts both totals. Both totals are visible on the outputs at all times and are read once the block's last descriptor has been taken.

Top module: `wcet_pipe_est`

## Requirements
- R1: `in_ready_o` is high at all times after reset, and one descriptor is taken on every clock edge where `in_valid_i` is high.
- R2: While reset is asserted and after it is released, both totals are 0.
- R3: With execute time E = min_exec + (rd + wr) × NCPA, the plain cost of an instruction is len × NCPA + E + p. The penalty p is 0 when rd and wr are both 0, 1 when exactly one of them is nonzero, and 2 when both are nonzero.
- R4: A descriptor taken with `blk_start_i` high is costed with a queued count of 0 and a residue of 0, and each total becomes that descriptor's cost alone.
- R5: When len ≤ the queued count f, the overlapped cost is E. It is E + (NCPA − h) when the instruction has data accesses and the residue h is nonzero.
- R6: When len > f, the overlapped cost is E + (len − f) × NCPA − h.
- R7: Bytes fetched during execution, g, are 0 for an instruction with data accesses. Otherwise g = floor(A / NCPA), where A = E, or A = E − (NCPA − h) when a residue is pending and E ≥ NCPA − h. The occupancy s is f + g, plus 1 when a pending residue fetch completes; it is len + g when len > f. The next f is min(s, QUEUE_BYTES) − len.
- R8: The next residue is 0 when the instruction has data accesses or s ≥ QUEUE_BYTES. It is E + h when a pending residue does not complete (no data access and E < NCPA − h). Otherwise it is A mod NCPA. It is always below NCPA.
- R9: The pipelined cost is the overlapped cost plus the same penalty p as in R3, so the pipelined total never exceeds the plain total.
- R10: Each total adds the cost of each descriptor taken and holds at 2^TOT_W − 1 instead of wrapping.
- R11: On an edge where `in_valid_i` is low, neither the totals nor the carried state change, whatever `blk_start_i` and the data inputs show.
- R12: `op_len_i` is in the range 1 to QUEUE_BYTES whenever `in_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Descriptor present |
| in_ready_o | output | 1 | Descriptor can be taken |
| blk_start_i | input | 1 | Descriptor is the first of a new block |
| op_len_i | input | LEN_W | Opcode length in bytes |
| rd_bytes_i | input | ACC_W | Data bytes read |
| wr_bytes_i | input | ACC_W | Data bytes written |
| min_exec_i | input | MIN_W | Minimum execute cycles |
| total_pipe_o | output | TOT_W | Pipelined worst-case total |
| total_naive_o | output | TOT_W | Non-overlapped total |

## Verification
The hardest state to reach from the ports is a nonzero residue followed by an instruction whose opcode is already queued. Only an instruction with no data accesses, whose execute time is not a multiple of the access time and which leaves the queue short of full, creates that state, and the next instruction must be short enough to hit. The bench builds this case on purpose, once with a data-access follower and once with a long-opcode follower. It also runs a long pseudo-random stream weighted toward access-free instructions with execute times below four accesses, so that residues of every value meet hits, misses and near-full queues. Saturation is reached on a narrowed total width so that it takes only a few dozen descriptors.

// File: rtl/wcet_pkg.sv
package wcet_pkg;

  typedef enum logic [1:0] {
    FK_MISS,
    FK_CLEAN,
    FK_RESIDUE
  } fetch_kind_e;

  // handshake penalty: one per access direction in use
  function automatic logic [1:0] hs_penalty(input logic rd_nz, input logic wr_nz);
    if (rd_nz && wr_nz) return 2'd2;
    if (rd_nz || wr_nz) return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/wcet_step.sv
module wcet_step
  import wcet_pkg::*;
#(
  parameter int NCPA        = 4,
  parameter int QUEUE_BYTES = 4,
  parameter int LEN_W       = 3,
  parameter int ACC_W       = 4,
  parameter int MIN_W       = 8,
  parameter int F_W         = 3,
  parameter int H_W         = 3,
  parameter int CW          = 21
) (
  input  logic [LEN_W-1:0] op_len_i,
  input  logic [ACC_W-1:0] rd_bytes_i,
  input  logic [ACC_W-1:0] wr_bytes_i,
  input  logic [MIN_W-1:0] min_exec_i,
  input  logic [F_W-1:0]   f_prev_i,
  input  logic [H_W-1:0]   h_prev_i,
  output logic [CW-1:0]    pipe_cost_o,
  output logic [CW-1:0]    naive_cost_o,
  output logic [F_W-1:0]   f_next_o,
  output logic [H_W-1:0]   h_next_o
);

  localparam logic [CW-1:0] NC = CW'(NCPA);
  localparam logic [CW-1:0] QB = CW'(QUEUE_BYTES);

  logic [CW-1:0] len_w, f_w, h_w, e_w, wait_w, avail_w;
  logic [CW-1:0] g_w, rem_w, s_w, s_cl, b_w, hs_w, h_nx;
  logic          mem, avail_ok, res_done;
  fetch_kind_e   kind;

  always_comb begin
    len_w  = CW'(op_len_i);
    f_w    = CW'(f_prev_i);
    h_w    = CW'(h_prev_i);
    mem    = (|rd_bytes_i) || (|wr_bytes_i);
    e_w    = CW'(min_exec_i) + (CW'(rd_bytes_i) + CW'(wr_bytes_i)) * NC;
    hs_w   = CW'(hs_penalty(|rd_bytes_i, |wr_bytes_i));
    wait_w = NC - h_w;

    if (len_w > f_w)    kind = FK_MISS;
    else if (h_w != '0) kind = FK_RESIDUE;
    else                kind = FK_CLEAN;

    b_w      = e_w;
    avail_ok = !mem;
    avail_w  = e_w;
    res_done = 1'b0;
    unique case (kind)
      FK_MISS: b_w = e_w + (len_w - f_w) * NC - h_w;
      FK_RESIDUE: begin
        if (mem) begin
          // access waits for the in-flight fetch to land
          b_w      = e_w + wait_w;
          res_done = 1'b1;
        end else if (e_w >= wait_w) begin
          avail_w  = e_w - wait_w;
          res_done = 1'b1;
        end else begin
          avail_ok = 1'b0;
        end
      end
      default: ;
    endcase

    g_w   = avail_ok ? avail_w / NC : '0;
    rem_w = avail_ok ? avail_w % NC : '0;
    s_w   = ((kind == FK_MISS) ? len_w : f_w) + g_w + CW'(res_done);
    s_cl  = (s_w > QB) ? QB : s_w;

    if (mem || s_w >= QB)                    h_nx = '0;
    else if (kind == FK_RESIDUE && !res_done) h_nx = e_w + h_w;
    else                                     h_nx = rem_w;

    f_next_o     = F_W'(s_cl - len_w);
    h_next_o     = H_W'(h_nx);
    pipe_cost_o  = b_w + hs_w;
    naive_cost_o = len_w * NC + e_w + hs_w;
  end

endmodule

// File: rtl/wcet_sat_acc.sv
module wcet_sat_acc #(
  parameter int IN_W  = 21,
  parameter int TOT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [IN_W-1:0]  add_i,
  output logic [TOT_W-1:0] sum_o
);

  localparam int SW = ((IN_W > TOT_W) ? IN_W : TOT_W) + 1;
  localparam logic [SW-1:0] TOP = (SW'(1) << TOT_W) - SW'(1);

  logic [SW-1:0]    base, sum_w;
  logic [TOT_W-1:0] sum_q;

  always_comb begin
    base  = clr_i ? '0 : SW'(sum_q);
    sum_w = base + SW'(add_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= (sum_w > TOP) ? '1 : TOT_W'(sum_w);
  end

  assign sum_o = sum_q;

  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (sum_q >= $past(sum_q)));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sum_q));

endmodule

// File: rtl/wcet_pipe_est.sv
module wcet_pipe_est
  import wcet_pkg::*;
#(
  parameter int NCPA        = 4,
  parameter int QUEUE_BYTES = 4,
  parameter int LEN_W       = 3,
  parameter int ACC_W       = 4,
  parameter int MIN_W       = 8,
  parameter int TOT_W       = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             blk_start_i,
  input  logic [LEN_W-1:0] op_len_i,
  input  logic [ACC_W-1:0] rd_bytes_i,
  input  logic [ACC_W-1:0] wr_bytes_i,
  input  logic [MIN_W-1:0] min_exec_i,
  output logic [TOT_W-1:0] total_pipe_o,
  output logic [TOT_W-1:0] total_naive_o
);

  localparam int F_W     = $clog2(QUEUE_BYTES + 1);
  localparam int H_W     = $clog2(NCPA + 1);
  localparam int CW      = MIN_W + ACC_W + LEN_W + $clog2(NCPA + 1) + 3;
  localparam int NUM_ACC = 2;

  logic           accept;
  logic [F_W-1:0] f_q, f_prev, f_next;
  logic [H_W-1:0] h_q, h_prev, h_next;
  logic [CW-1:0]  cost [NUM_ACC];
  logic [TOT_W-1:0] tot [NUM_ACC];

  assign in_ready_o = 1'b1;
  assign accept     = in_valid_i && in_ready_o;
  assign f_prev     = blk_start_i ? '0 : f_q;
  assign h_prev     = blk_start_i ? '0 : h_q;

  wcet_step #(
    .NCPA(NCPA), .QUEUE_BYTES(QUEUE_BYTES), .LEN_W(LEN_W), .ACC_W(ACC_W),
    .MIN_W(MIN_W), .F_W(F_W), .H_W(H_W), .CW(CW)
  ) u_step (
    .op_len_i    (op_len_i),
    .rd_bytes_i  (rd_bytes_i),
    .wr_bytes_i  (wr_bytes_i),
    .min_exec_i  (min_exec_i),
    .f_prev_i    (f_prev),
    .h_prev_i    (h_prev),
    .pipe_cost_o (cost[0]),
    .naive_cost_o(cost[1]),
    .f_next_o    (f_next),
    .h_next_o    (h_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= '0;
      h_q <= '0;
    end else if (accept) begin
      f_q <= f_next;
      h_q <= h_next;
    end
  end

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    wcet_sat_acc #(.IN_W(CW), .TOT_W(TOT_W)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (accept),
      .clr_i (blk_start_i),
      .add_i (cost[k]),
      .sum_o (tot[k])
    );
  end

  assign total_pipe_o  = tot[0];
  assign total_naive_o = tot[1];

  assert_len_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (op_len_i != '0 && int'(op_len_i) <= QUEUE_BYTES));

  assert_queue_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(f_q) < QUEUE_BYTES);

  assert_residue_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(h_q) < NCPA);

  assert_pipe_le_naive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total_pipe_o <= total_naive_o);

  assert_state_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(f_q) && $stable(h_q)));

endmodule

// File: tb/wcet_pipe_est_test.sv
module wcet_pipe_est_test;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int Q    = 4;
  localparam int TW   = 12;
  localparam int MAXT = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic blk_start = 1'b0;
  logic [2:0] op_len = 3'd1;
  logic [3:0] rd_b = '0, wr_b = '0;
  logic [7:0] min_x = '0;
  logic [TW-1:0] tot_pipe, tot_naive;

  int errors = 0;
  int checks = 0;
  int mf = 0, mh = 0, tp = 0, tn = 0;
  int unsigned seed = 32'h1f2e3d4c;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcet_pipe_est #(.NCPA(N), .QUEUE_BYTES(Q), .LEN_W(3), .ACC_W(4), .MIN_W(8), .TOT_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .blk_start_i(blk_start), .op_len_i(op_len), .rd_bytes_i(rd_b), .wr_bytes_i(wr_b),
    .min_exec_i(min_x), .total_pipe_o(tot_pipe), .total_naive_o(tot_naive)
  );

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference cost from the requirement formulas
  task automatic model(input int len, input int rd, input int wr, input int mn,
                       input bit sob, output int pc, output int nc);
    int e, hs, b, s, hn, w;
    bit mem;
    if (sob) begin mf = 0; mh = 0; end
    mem = (rd != 0) || (wr != 0);
    e   = mn + (rd + wr) * N;
    hs  = (rd != 0 && wr != 0) ? 2 : (mem ? 1 : 0);
    nc  = len * N + e + hs;
    if (len > mf) begin
      b  = e + (len - mf) * N - mh;
      s  = len + (mem ? 0 : e / N);
      hn = mem ? 0 : e % N;
    end else if (mh == 0) begin
      b  = e;
      s  = mf + (mem ? 0 : e / N);
      hn = mem ? 0 : e % N;
    end else begin
      w = N - mh;
      if (mem) begin
        b = e + w; s = mf + 1; hn = 0;
      end else if (e >= w) begin
        b = e; s = mf + (e - w) / N + 1; hn = (e - w) % N;
      end else begin
        b = e; s = mf; hn = e + mh;
      end
    end
    if (mem || s >= Q) hn = 0;
    mf = ((s > Q) ? Q : s) - len;
    mh = hn;
    pc = b + hs;
  endtask

  task automatic send(input int len, input int rd, input int wr, input int mn,
                      input bit sob, input string tag);
    int pc, nc;
    model(len, rd, wr, mn, sob, pc, nc);
    if (sob) begin tp = 0; tn = 0; end
    tp = (tp + pc > MAXT) ? MAXT : tp + pc;
    tn = (tn + nc > MAXT) ? MAXT : tn + nc;
    @(negedge clk);
    in_valid  = 1'b1;
    blk_start = sob;
    op_len    = 3'(len);
    rd_b      = 4'(rd);
    wr_b      = 4'(wr);
    min_x     = 8'(mn);
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    blk_start = 1'b0;
    check({tag, " pipe R9"}, int'(tot_pipe), tp);
    check({tag, " naive R3"}, int'(tot_naive), tn);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int left, hold_p, hold_n;
    repeat (3) @(negedge clk);
    check("R2 reset pipe", int'(tot_pipe), 0);
    check("R2 reset naive", int'(tot_naive), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2 after release pipe", int'(tot_pipe), 0);
    check("R1 ready", int'(in_ready), 1);

    // R4: every descriptor as the head of a fresh block
    for (int len = 1; len <= Q; len++)
      for (int rd = 0; rd <= 2; rd++)
        for (int wr = 0; wr <= 2; wr++)
          for (int m = 0; m < 8; m++)
            send(len, rd, wr, (m * 7) % 17, 1'b1, "R4/R5/R6 single");

    // R5: hit with pending residue and a data access
    send(1, 0, 0, 6, 1'b1, "R5 residue setup");
    send(1, 1, 0, 2, 1'b0, "R5 hit residue");
    check("R5 hit residue pipe const", int'(tot_pipe), 19);
    check("R5 hit residue naive const", int'(tot_naive), 21);

    // R6: miss while a residue is pending
    send(1, 0, 0, 6, 1'b1, "R6 residue setup");
    send(3, 0, 0, 0, 1'b0, "R6 miss residue");
    check("R6 miss residue pipe const", int'(tot_pipe), 16);
    check("R6 miss residue naive const", int'(tot_naive), 22);

    // R7/R8: pseudo-random streams carrying queue and residue state
    left = 0;
    for (int i = 0; i < 4000; i++) begin
      bit sob;
      int len, rd, wr, mn, sel;
      sob = (left == 0);
      if (sob) left = 1 + int'(rnd() % 8);
      left--;
      len = 1 + int'(rnd() % 4);
      sel = int'(rnd() % 8);
      rd  = (sel == 0) ? int'(rnd() % 3) : 0;
      wr  = (sel == 1) ? 1 + int'(rnd() % 2) : ((sel == 2) ? int'(rnd() % 3) : 0);
      mn  = int'(rnd() % 16);
      send(len, rd, wr, mn, sob, "R7/R8 stream");
    end

    // R11: idle edges with start flag and junk data have no effect
    send(1, 0, 0, 7, 1'b1, "R11 setup");
    hold_p = int'(tot_pipe);
    hold_n = int'(tot_naive);
    @(negedge clk);
    blk_start = 1'b1; op_len = 3'd4; rd_b = 4'd3; wr_b = 4'd3; min_x = 8'd200;
    repeat (4) @(negedge clk);
    blk_start = 1'b0;
    check("R11 idle pipe", int'(tot_pipe), hold_p);
    check("R11 idle naive", int'(tot_naive), hold_n);
    send(1, 0, 0, 3, 1'b0, "R11 state kept");

    // R10: saturation, then restart
    send(4, 2, 2, 255, 1'b1, "R10 sat");
    for (int i = 0; i < 19; i++) send(4, 2, 2, 255, 1'b0, "R10 sat");
    check("R10 pipe saturated", int'(tot_pipe), MAXT);
    check("R10 naive saturated", int'(tot_naive), MAXT);
    send(1, 0, 0, 0, 1'b1, "R4 restart");
    check("R4 restart pipe const", int'(tot_pipe), 4);
    check("R1 ready end", int'(in_ready), 1);

    summary();
    $finish;
  end

endmodule